// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

This block is one logic slice of a small programmable logic fabric. It accepts 36 routed input signals and forms a true and an inverted literal from each one. It builds 86 product terms by ANDing the literals that configuration selects. A steering network then ORs any subset of those terms into each of 16 sum outputs. A single term can feed several sums at once, so a sub-expression that several outputs share is built only once. The number of terms a sum receives can be anything from none up to a fixed ceiling.

Configuration sits in static registers. A parallel write port loads them one term at a time: a term index, a field selector and a data word, qualified by a program-enable input. The sum outputs are combinational functions of the input pins and the stored configuration. The only clocked state is the configuration itself.

Top module: `pla_block`

## Requirements
- R1: Literal column 2k carries input pin k unchanged, and column 2k+1 carries its inverse. A term that selects both columns of one pin is always 0.
- R2: An enabled product term is the AND of the literals its 72-bit mask selects (mask bit c selects column c). An enabled term with an all-zero mask evaluates to 1.
- R3: A term whose enable bit is clear contributes 0 to every sum, whatever its mask.
- R4: Sum output j is the OR of the enabled terms whose steering bit j is set. A sum with no steered terms is 0.
- R5: One term steered to several outputs drives all of them at the same time.
- R6: No sum output may have more than 16 steered terms. A steering write that would push any output past 16 is discarded in full, and 16 itself is accepted.
- R7: A write happens at a rising clock edge only while `prog_en` is high and `cfg_term` is below 86. The field encoding is `cfg_field`=0 for the literal mask (`cfg_data[71:0]`), and `cfg_field`=1 for the steering row (`cfg_data[15:0]`, bit j to output j) together with the term enable (`cfg_data[16]`). Any other write has no effect.
- R8: A synchronous active-high `rst` clears all masks, steering rows and enables, so every sum reads 0.
- R9: The sums follow a change on `pins` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset of the configuration |
| prog_en | input | 1 | Enables a configuration write at the rising edge |
| cfg_term | input | 7 | Index of the product term being written |
| cfg_field | input | 1 | 0 selects the literal mask, 1 selects the steering row and enable |
| cfg_data | input | 72 | Write data |
| pins | input | 36 | Routed input signals |
| sums | output | 16 | Sum-of-products outputs |

## Verification
A change on `pins` is due on `sums` in the same cycle, with zero clock edges. The bench therefore changes pins just after a falling edge and samples 1 ns later, well before the next rising edge. A configuration write becomes visible after the single rising edge at which `prog_en` is sampled high. The bench holds the write across exactly one rising edge and then compares at the following falling edge. A behavioural reference built from loops over the bench's own copy of the configuration gives the expected sums for every sample, including rejected and ignored writes.

// File: rtl/pla_pkg.sv
package pla_pkg;
    parameter int N_IN   = 36;
    parameter int N_PT   = 86;
    parameter int N_OUT  = 16;
    parameter int MAX_PT = 16;

    localparam int LIT_W   = 2 * N_IN;
    localparam int TERM_AW = $clog2(N_PT);
    localparam int CNT_W   = $clog2(N_PT + 1);
    localparam int CFG_W   = (LIT_W > N_OUT + 1) ? LIT_W : N_OUT + 1;
    localparam int EN_BIT  = N_OUT;

    typedef enum logic {
        FLD_LIT   = 1'b0,
        FLD_STEER = 1'b1
    } cfg_field_e;

    typedef logic [N_PT-1:0][LIT_W-1:0] lit_mask_t;
    typedef logic [N_PT-1:0][N_OUT-1:0] steer_t;
    typedef logic [N_PT-1:0]            term_vec_t;

    function automatic term_vec_t steer_column(input steer_t s, input int j);
        term_vec_t c;
        for (int t = 0; t < N_PT; t++) c[t] = s[t][j];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] count_ones(input term_vec_t v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int t = 0; t < N_PT; t++) n = n + CNT_W'(v[t]);
        return n;
    endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
    import pla_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_en,
    input  logic [TERM_AW-1:0] wr_term,
    input  logic               wr_field,
    input  logic [CFG_W-1:0]   wr_data,
    output lit_mask_t          lit_mask,
    output steer_t             steer,
    output term_vec_t          term_en
);
    lit_mask_t lit_q;
    steer_t    steer_q;
    term_vec_t en_q;

    logic               addr_ok;
    logic [TERM_AW-1:0] idx;
    logic [N_OUT-1:0]   new_row;
    logic [N_OUT-1:0]   old_row;
    logic [CNT_W-1:0]   col_cnt [N_OUT];
    logic               fits;
    cfg_field_e         field;

    assign addr_ok = (wr_term < TERM_AW'(N_PT));
    assign idx     = addr_ok ? wr_term : '0;
    assign new_row = wr_data[N_OUT-1:0];
    assign old_row = steer_q[idx];
    assign field   = cfg_field_e'(wr_field);

    // Per-output occupancy and the ceiling test for a pending steering write
    always_comb begin
        logic [CNT_W:0] after;
        fits = 1'b1;
        for (int j = 0; j < N_OUT; j++) begin
            col_cnt[j] = count_ones(steer_column(steer_q, j));
            after = {1'b0, col_cnt[j]} + {{CNT_W{1'b0}}, new_row[j]}
                    - {{CNT_W{1'b0}}, old_row[j]};
            if (after > (CNT_W+1)'(MAX_PT)) fits = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lit_q   <= '0;
            steer_q <= '0;
            en_q    <= '0;
        end else if (prog_en && addr_ok) begin
            if (field == FLD_LIT) begin
                lit_q[idx] <= wr_data[LIT_W-1:0];
            end else if (fits) begin
                steer_q[idx] <= new_row;
                en_q[idx]    <= wr_data[EN_BIT];
            end
        end
    end

    assign lit_mask = lit_q;
    assign steer    = steer_q;
    assign term_en  = en_q;

    // R7
    no_prog_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !prog_en |=> ($stable(lit_q) && $stable(steer_q) && $stable(en_q)));

    generate
        for (genvar j = 0; j < N_OUT; j++) begin : g_limit
            // R6
            out_term_limit_chk: assert property (@(posedge clk) disable iff (rst)
                col_cnt[j] <= CNT_W'(MAX_PT));
        end
    endgenerate
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] pins,
    input  lit_mask_t       lit_mask,
    input  term_vec_t       term_en,
    output term_vec_t       terms
);
    logic [LIT_W-1:0] lits;

    generate
        for (genvar k = 0; k < N_IN; k++) begin : g_lit
            assign lits[2*k]   = pins[k];
            assign lits[2*k+1] = ~pins[k];
        end

        for (genvar t = 0; t < N_PT; t++) begin : g_term
            assign terms[t] = term_en[t] & (&(lits | ~lit_mask[t]));

            // R2
            empty_term_high_chk: assert property (@(posedge clk) disable iff (rst)
                (term_en[t] && lit_mask[t] == '0) |-> terms[t]);

            // R1
            both_polarity_low_chk: assert property (@(posedge clk) disable iff (rst)
                (lit_mask[t][1:0] == 2'b11) |-> !terms[t]);
        end
    endgenerate
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  term_vec_t        terms,
    input  steer_t           steer,
    output logic [N_OUT-1:0] sums
);
    generate
        for (genvar j = 0; j < N_OUT; j++) begin : g_sum
            term_vec_t col;
            assign col     = steer_column(steer, j);
            assign sums[j] = |(terms & col);

            // R4
            empty_sum_low_chk: assert property (@(posedge clk) disable iff (rst)
                (col == '0) |-> !sums[j]);
        end
    endgenerate
endmodule

// File: rtl/pla_block.sv
module pla_block
    import pla_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_en,
    input  logic [TERM_AW-1:0] cfg_term,
    input  logic               cfg_field,
    input  logic [CFG_W-1:0]   cfg_data,
    input  logic [N_IN-1:0]    pins,
    output logic [N_OUT-1:0]   sums
);
    lit_mask_t lit_mask;
    steer_t    steer;
    term_vec_t term_en;
    term_vec_t terms;

    pla_cfg_store u_store (
        .clk      (clk),
        .rst      (rst),
        .prog_en  (prog_en),
        .wr_term  (cfg_term),
        .wr_field (cfg_field),
        .wr_data  (cfg_data),
        .lit_mask (lit_mask),
        .steer    (steer),
        .term_en  (term_en)
    );

    pla_and_plane u_and (
        .clk      (clk),
        .rst      (rst),
        .pins     (pins),
        .lit_mask (lit_mask),
        .term_en  (term_en),
        .terms    (terms)
    );

    pla_or_plane u_or (
        .clk   (clk),
        .rst   (rst),
        .terms (terms),
        .steer (steer),
        .sums  (sums)
    );
endmodule

// File: tb/pla_block_tb_top.sv
`timescale 1ns/1ps
module pla_block_tb_top;
    localparam int NI = 36;
    localparam int NT = 86;
    localparam int NO = 16;
    localparam int LIM = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_en = 1'b0;
    logic [6:0]  cfg_term = '0;
    logic        cfg_field = 1'b0;
    logic [71:0] cfg_data = '0;
    logic [35:0] pins = '0;
    logic [15:0] sums;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [71:0] m_lit   [NT];
    logic [15:0] m_steer [NT];
    bit          m_en    [NT];

    always #5 clk = ~clk;

    pla_block dut_i (
        .clk(clk), .rst(rst), .prog_en(prog_en), .cfg_term(cfg_term),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .pins(pins), .sums(sums)
    );

    function automatic logic [15:0] model_sums(input logic [35:0] p);
        logic [15:0] s = '0;
        for (int t = 0; t < NT; t++) begin
            bit prod = m_en[t];
            for (int k = 0; k < NI; k++) begin
                if (m_lit[t][2*k] && !p[k]) prod = 0;
                if (m_lit[t][2*k+1] && p[k]) prod = 0;
            end
            if (prod) s = s | m_steer[t];
        end
        return s;
    endfunction

    task automatic model_clear();
        for (int t = 0; t < NT; t++) begin
            m_lit[t] = '0; m_steer[t] = '0; m_en[t] = 0;
        end
    endtask

    task automatic model_write(input bit pe, input int term, input bit fld, input logic [71:0] d);
        if (!pe || term >= NT) return;
        if (fld == 1'b0) begin
            m_lit[term] = d;
        end else begin
            bit ok = 1;
            for (int j = 0; j < NO; j++) begin
                int n = d[j] ? 1 : 0;
                for (int t = 0; t < NT; t++) if (t != term && m_steer[t][j]) n++;
                if (n > LIM) ok = 0;
            end
            if (ok) begin
                m_steer[term] = d[15:0];
                m_en[term] = d[16];
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic wr(input bit pe, input int term, input bit fld, input logic [71:0] d);
        @(negedge clk);
        prog_en = pe; cfg_term = 7'(term); cfg_field = fld; cfg_data = d;
        @(posedge clk);
        model_write(pe, term, fld, d);
        @(negedge clk);
        prog_en = 1'b0;
    endtask

    task automatic check_val(input string req, input logic [15:0] exp);
        checks++;
        if (sums !== exp) begin
            errors++;
            $display("FAIL %s: sums=%h expected %h", req, sums, exp);
        end
    endtask

    task automatic apply_and_check(input string req, input logic [35:0] p);
        pins = p;
        #1;
        check_val(req, model_sums(p));
    endtask

    function automatic logic [71:0] steer_word(input logic [15:0] row, input bit en);
        return {55'b0, en, row};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: sums=%h expected run to finish", sums);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        // R8: everything cleared after reset
        pins = 36'hF_0F0F_0F0F;
        #1;
        check_val("R8 reset", 16'h0000);
        // R4: no terms steered anywhere
        apply_and_check("R4 empty", 36'h5_A5A5_A5A5);

        // R2: empty mask, enabled term steered to output 3
        wr(1, 0, 1'b1, steer_word(16'h0008, 1));
        @(negedge clk);
        apply_and_check("R2 empty term", 36'h0_0000_0000);
        check_val("R2 empty term literal", 16'h0008);
        apply_and_check("R2 empty term", 36'hF_FFFF_FFFF);

        // R3: clear enable, mask stays empty
        wr(1, 0, 1'b1, steer_word(16'h0008, 0));
        @(negedge clk);
        apply_and_check("R3 disabled", 36'h0_0000_0000);
        check_val("R3 disabled literal", 16'h0000);

        // R1/R5: pin2 true (col 4), pin7 inverted (col 15), shared to outputs 0 and 9
        wr(1, 5, 1'b0, 72'h0 | (72'd1 << 4) | (72'd1 << 15));
        wr(1, 5, 1'b1, steer_word(16'h0201, 1));
        @(negedge clk);
        apply_and_check("R1 match", 36'h0_0000_0004);
        check_val("R5 shared", 16'h0201);
        apply_and_check("R1 mismatch", 36'h0_0000_0084);
        check_val("R1 mismatch literal", 16'h0000);
        // R9: pins change between edges, sums follow at once
        @(negedge clk);
        #2;
        pins = 36'h0_0000_0004;
        #1;
        check_val("R9 combinational", 16'h0201);

        // R7: writes with prog_en low, or to an out-of-range term, do nothing
        wr(0, 5, 1'b1, steer_word(16'h0000, 0));
        wr(0, 5, 1'b0, 72'h3);
        wr(1, 100, 1'b1, steer_word(16'hFFFF, 1));
        @(negedge clk);
        apply_and_check("R7 ignored", 36'h0_0000_0004);
        check_val("R7 ignored literal", 16'h0201);

        // R1: both polarities of pin 0 makes the term 0; fill output 15 with 16 such terms
        for (int t = 10; t < 26; t++) begin
            wr(1, t, 1'b0, 72'h3);
            wr(1, t, 1'b1, steer_word(16'h8000, 1));
        end
        @(negedge clk);
        apply_and_check("R1 contradiction", 36'hF_FFFF_FFFF);
        check_val("R1 contradiction literal", 16'h0000);

        // R6: a 17th term for output 15 is refused as a whole (output 14 stays clear)
        wr(1, 26, 1'b1, steer_word(16'hC000, 1));
        @(negedge clk);
        apply_and_check("R6 over limit", 36'h1_2345_6789);
        check_val("R6 over limit literal", 16'h0000);
        // free one slot, then the same write lands at exactly 16
        wr(1, 10, 1'b1, steer_word(16'h0000, 0));
        wr(1, 26, 1'b1, steer_word(16'hC000, 1));
        @(negedge clk);
        apply_and_check("R6 at limit", 36'h0_0000_0000);
        check_val("R6 at limit literal", 16'hC000);

        // R8: reset again wipes the configuration
        do_reset();
        apply_and_check("R8 re-reset", 36'h0_0000_0004);
        check_val("R8 re-reset literal", 16'h0000);

        // R2 R4 R5 R6: random configurations against the reference
        for (int cfg = 0; cfg < 12; cfg++) begin
            do_reset();
            for (int t = 0; t < NT; t++) begin
                logic [71:0] m = '0;
                logic [15:0] r = '0;
                for (int b = 0; b < 72; b++) if ($urandom % 24 == 0) m[b] = 1'b1;
                for (int j = 0; j < NO; j++) if ($urandom % 9 == 0) r[j] = 1'b1;
                wr(1, t, 1'b0, m);
                wr(1, t, 1'b1, steer_word(r, ($urandom % 6) != 0));
            end
            for (int v = 0; v < 24; v++) begin
                @(negedge clk);
                apply_and_check("R4 random", 36'({$urandom, $urandom}));
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule